// File: doc/BRIEF.md
# Ethernet Multicast Hash Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether a frame should be kept, based only on its 48-bit destination address. The address arrives one byte per cycle with a strobe, the first byte on the wire first. The first byte also carries a start-of-frame flag. While the bytes arrive the block runs a reflected CRC-32 over them. The cycle after the sixth byte, it reports a one-cycle accept/reject verdict together with the 6-bit hash index it used.

Software programs a small register file through a single-cycle write port: a 64-bit hash table held as two 32-bit words, a 48-bit station address in two words, and a receive-mode word. The receive-mode word holds independent enables. One accepts every frame. One accepts all group (multicast) addresses. One accepts group addresses whose hash table bit is set. One accepts the broadcast address. One accepts unicast frames addressed to the station. A further enable bit for VLAN matching is stored and brought out for the downstream tag logic. A frame is accepted when any enabled category claims it.

Top module: `mcast_addr_filter`

## Requirements
- R1: While reset is held and straight after it, result_valid_o, accept_o and vlan_match_en_o are 0. All configuration registers are cleared, so every frame is rejected until a receive-mode word is written.
- R2: The hash index is formed as follows. A CRC-32 is taken over the six address bytes in arrival order, each byte least significant bit first, with the reflected polynomial 0xEDB88320, a start value of 0xFFFFFFFF and no final inversion. CRC bit 31-k becomes index bit k, for k = 0..5. hash_idx_o shows that index from the result cycle onwards, and address 01-80-C2-00-00-01 gives index 0x39.
- R3: result_valid_o is high for exactly one cycle: the cycle after the clock edge that takes the sixth address byte. accept_o is 0 whenever result_valid_o is 0. Bytes that arrive after the sixth and before the next start-of-frame are ignored.
- R4: A byte presented with sof_i=1 and byte_valid_i=1 always becomes address byte 0 and restarts the CRC, even in the middle of an address. sof_i without byte_valid_i has no effect, and byte_valid_i=0 cycles inside an address simply pause it.
- R5: With receive-mode bit 3 (all frames) set, every frame is accepted.
- R6: With receive-mode bit 1 (all multicast) set, every frame whose group bit is set and that is not broadcast is accepted. The group bit is bit 0 of the first byte.
- R7: With receive-mode bit 4 (hash multicast) set, a non-broadcast group frame is accepted when its table bit is set. The table bit is bit index%32 of hash word index/32. Word 0 is written at configuration address 0 and word 1 at address 1.
- R8: The broadcast address (all 48 bits set) is accepted only by receive-mode bit 2 (broadcast) or bit 3. Bits 1 and 4 never accept it.
- R9: With receive-mode bit 0 (unicast) set, a frame whose group bit is clear is accepted when all 48 bits equal the station address. Configuration address 2 holds address bytes 0..3, with byte 0 in bits 7:0. Configuration address 3 holds bytes 4..5 in bits 15:0.
- R10: Configuration address 4 holds the receive-mode word in bits 5:0, and bit 5 drives vlan_match_en_o. A configuration write takes effect from the following cycle. A write at the same edge as the sixth byte does not affect that frame's verdict.
- R11: A frame is accepted exactly when at least one enabled category claims it. The enables combine as a logical OR, and with no category enabled the frame is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the first address byte; qualified by byte_valid_i |
| byte_valid_i | input | 1 | Address byte strobe |
| byte_i | input | 8 | Address byte, first wire byte first |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| result_valid_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Frame accepted; meaningful only with result_valid_o |
| hash_idx_o | output | 6 | Hash index of the last completed address |
| vlan_match_en_o | output | 1 | Stored VLAN match enable |

## Verification
Two functions can fall in the same cycle. A configuration write can land on the same edge as the sixth address byte. Separately, the start-of-frame byte of the next frame can arrive in the cycle that presents the previous frame's verdict. The bench provokes the first case by rewriting the receive-mode word or a hash word on the final byte, and expects the verdict to follow the old contents. It provokes the second with back-to-back addresses and checks each verdict against its own address and its own pulse. A behavioural model tracks both cases on every clock.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int MODE_W = 6;

  // bit 5 .. bit 0
  typedef struct packed {
    logic vlan_en;
    logic hash_en;
    logic all_en;
    logic bcast_en;
    logic mcast_en;
    logic uni_en;
  } rx_mode_t;
endpackage

// File: rtl/maf_crc_byte.sv
module maf_crc_byte #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stg [DATA_W+1];

  assign stg[0] = crc_i ^ {{(CRC_W-DATA_W){1'b0}}, data_i};

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign stg[g+1] = stg[g][0] ? ((stg[g] >> 1) ^ POLY[CRC_W-1:0]) : (stg[g] >> 1);
  end

  assign crc_o = stg[DATA_W];
endmodule

// File: rtl/maf_addr_capture.sv
module maf_addr_capture #(
  parameter int          ADDR_BYTES = 6,
  parameter int          CRC_W      = 32,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] POLY       = 32'hEDB88320,
  localparam int         ADDR_W     = ADDR_BYTES * 8,
  localparam int         CNT_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 byte_valid_i,
  input  logic [7:0]           byte_i,
  output logic                 last_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [HASH_BITS-1:0] crc_top_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  pos;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_in;
  logic [CRC_W-1:0]  crc_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_cur;
  logic              take;

  // idle when cnt_q == ADDR_BYTES
  assign take   = byte_valid_i && (sof_i || (cnt_q < CNT_W'(ADDR_BYTES)));
  assign pos    = sof_i ? '0 : cnt_q;
  assign crc_in = sof_i ? '1 : crc_q;
  assign last_o = take && (pos == CNT_W'(ADDR_BYTES - 1));

  maf_crc_byte #(.CRC_W(CRC_W), .DATA_W(8), .POLY(POLY)) u_crc (
    .crc_i (crc_in),
    .data_i(byte_i),
    .crc_o (crc_nxt)
  );

  // address including the byte on the bus this cycle
  always_comb begin
    addr_cur = addr_q;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (take && (pos == CNT_W'(b))) addr_cur[b*8 +: 8] = byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(ADDR_BYTES);
      crc_q  <= '1;
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= pos + CNT_W'(1);
      crc_q  <= crc_nxt;
      addr_q <= addr_cur;
    end
  end

  assign addr_o    = addr_cur;
  assign crc_top_o = crc_nxt[CRC_W-1 -: HASH_BITS];
endmodule

// File: rtl/maf_cfg_regs.sv
module maf_cfg_regs
  import maf_pkg::*;
#(
  parameter int  WORD_W    = 32,
  parameter int  TABLE_W   = 64,
  parameter int  STA_W     = 48,
  parameter int  CFG_AW    = 3,
  localparam int NUM_WORDS = TABLE_W / WORD_W,
  localparam int STA_HI_W  = STA_W - WORD_W,
  localparam int A_STA_LO  = NUM_WORDS,
  localparam int A_STA_HI  = NUM_WORDS + 1,
  localparam int A_MODE    = NUM_WORDS + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [CFG_AW-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [TABLE_W-1:0] table_o,
  output logic [STA_W-1:0]   station_o,
  output rx_mode_t           mode_o
);
  logic [WORD_W-1:0]   tab_q [NUM_WORDS];
  logic [WORD_W-1:0]   sta_lo_q;
  logic [STA_HI_W-1:0] sta_hi_q;
  rx_mode_t            mode_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tab_q[w] <= '0;
      else if (we_i && (addr_i == CFG_AW'(w)))    tab_q[w] <= wdata_i;
    end
    assign table_o[w*WORD_W +: WORD_W] = tab_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      mode_q   <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_AW'(A_STA_LO)) sta_lo_q <= wdata_i;
      if (addr_i == CFG_AW'(A_STA_HI)) sta_hi_q <= wdata_i[STA_HI_W-1:0];
      if (addr_i == CFG_AW'(A_MODE))   mode_q   <= rx_mode_t'(wdata_i[MODE_W-1:0]);
    end
  end

  assign station_o = {sta_hi_q, sta_lo_q};
  assign mode_o    = mode_q;
endmodule

// File: rtl/maf_decide.sv
module maf_decide
  import maf_pkg::*;
#(
  parameter int  ADDR_BYTES = 6,
  parameter int  HASH_BITS  = 6,
  localparam int ADDR_W     = ADDR_BYTES * 8,
  localparam int TABLE_W    = 1 << HASH_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 last_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [HASH_BITS-1:0] crc_top_i,
  input  logic [TABLE_W-1:0]   table_i,
  input  logic [ADDR_W-1:0]    station_i,
  input  rx_mode_t             mode_i,
  output logic                 valid_o,
  output logic                 accept_o,
  output logic [HASH_BITS-1:0] idx_o
);
  logic [HASH_BITS-1:0] idx;
  logic is_grp, is_bc, hit, acc;

  // reversed bit order: top CRC bit lands in index bit 0
  for (genvar b = 0; b < HASH_BITS; b++) begin : g_rev
    assign idx[b] = crc_top_i[HASH_BITS-1-b];
  end

  assign is_grp = addr_i[0];
  assign is_bc  = &addr_i;
  assign hit    = table_i[idx];

  always_comb begin
    acc = mode_i.all_en;
    if (is_bc)       acc = acc | mode_i.bcast_en;
    else if (is_grp) acc = acc | mode_i.mcast_en | (mode_i.hash_en & hit);
    else             acc = acc | (mode_i.uni_en & (addr_i == station_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
      idx_o    <= '0;
    end else begin
      valid_o  <= last_i;
      accept_o <= last_i & acc;
      if (last_i) idx_o <= idx;
    end
  end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
  import maf_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter int          WORD_W     = 32,
  parameter int          CRC_W      = 32,
  parameter int          CFG_AW     = 3,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 byte_valid_i,
  input  logic [7:0]           byte_i,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [WORD_W-1:0]    cfg_wdata_i,
  output logic                 result_valid_o,
  output logic                 accept_o,
  output logic [HASH_BITS-1:0] hash_idx_o,
  output logic                 vlan_match_en_o
);
  localparam int ADDR_W  = ADDR_BYTES * 8;
  localparam int TABLE_W = 1 << HASH_BITS;

  logic                 last_w;
  logic [ADDR_W-1:0]    addr_w;
  logic [HASH_BITS-1:0] crc_top_w;
  logic [TABLE_W-1:0]   table_w;
  logic [ADDR_W-1:0]    station_w;
  rx_mode_t             mode_w;

  maf_addr_capture #(
    .ADDR_BYTES(ADDR_BYTES), .CRC_W(CRC_W), .HASH_BITS(HASH_BITS), .POLY(CRC_POLY)
  ) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .last_o      (last_w),
    .addr_o      (addr_w),
    .crc_top_o   (crc_top_w)
  );

  maf_cfg_regs #(
    .WORD_W(WORD_W), .TABLE_W(TABLE_W), .STA_W(ADDR_W), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .table_o  (table_w),
    .station_o(station_w),
    .mode_o   (mode_w)
  );

  maf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .last_i   (last_w),
    .addr_i   (addr_w),
    .crc_top_i(crc_top_w),
    .table_i  (table_w),
    .station_i(station_w),
    .mode_i   (mode_w),
    .valid_o  (result_valid_o),
    .accept_o (accept_o),
    .idx_o    (hash_idx_o)
  );

  assign vlan_match_en_o = mode_w.vlan_en;
endmodule

// File: rtl/maf_checker.sv
module maf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_i,
  input logic       result_valid_o,
  input logic       accept_o,
  input logic [5:0] mode_i
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o); // R3

  AST_VALID_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(byte_valid_i)); // R3

  AST_ACCEPT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> !accept_o); // R3

  AST_ALL_FRAMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && $past(mode_i[3])) |-> accept_o); // R5

  AST_NO_ENABLE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && ($past(mode_i[4:0]) == 5'd0)) |-> !accept_o); // R11
endmodule

bind mcast_addr_filter maf_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .byte_valid_i  (byte_valid_i),
  .result_valid_o(result_valid_o),
  .accept_o      (accept_o),
  .mode_i        (mode_w)
);

// File: tb/sim_mcast_addr_filter.sv
`timescale 1ns/1ps
module sim_mcast_addr_filter;
  logic        clk_i = 0, rst_ni = 0, sof_i = 0, byte_valid_i = 0;
  logic [7:0]  byte_i = 0;
  logic        cfg_we_i = 0;
  logic [2:0]  cfg_addr_i = 0;
  logic [31:0] cfg_wdata_i = 0;
  logic        result_valid_o, accept_o, vlan_match_en_o;
  logic [5:0]  hash_idx_o;

  int    checks = 0, errors = 0;
  string cur_req = "R11";
  bit    run_cmp = 0;

  always #2.5 clk_i = ~clk_i;

  mcast_addr_filter u0 (.*);

  localparam logic [47:0] PAUSE = 48'h01_00_00_C2_80_01; // bytes 01-80-C2-00-00-01
  localparam logic [47:0] BCAST = '1;

  task automatic chk(input longint act, input longint exp, input string r, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [5:0]  r;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    for (int k = 0; k < 6; k++) r[k] = c[31-k];
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_tab;
  logic [47:0] m_sta;
  logic [5:0]  m_mode;
  bit          m_act;
  logic [7:0]  q[$];
  bit          exp_valid, exp_acc;
  logic [5:0]  exp_idx;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tab = 0; m_sta = 0; m_mode = 0; m_act = 0; q = {};
      exp_valid = 0; exp_acc = 0; exp_idx = 0;
    end else begin
      exp_valid = 0; exp_acc = 0;
      if (byte_valid_i) begin
        if (sof_i) begin q = {}; m_act = 1; end
        if (m_act) begin
          q.push_back(byte_i);
          if (q.size() == 6) begin
            logic [47:0] a;
            bit grp, bc, acc;
            for (int i = 0; i < 6; i++) a[i*8 +: 8] = q[i];
            exp_idx = ref_idx(a);
            grp = a[0]; bc = (a == BCAST);
            acc = m_mode[3];
            if (bc) acc = acc | m_mode[2];
            else if (grp) acc = acc | m_mode[1] | (m_mode[4] & m_tab[exp_idx]);
            else acc = acc | (m_mode[0] & (a == m_sta));
            exp_valid = 1; exp_acc = acc; m_act = 0;
          end
        end
      end
      if (cfg_we_i) begin
        case (cfg_addr_i)
          3'd0: m_tab[31:0]  = cfg_wdata_i;
          3'd1: m_tab[63:32] = cfg_wdata_i;
          3'd2: m_sta[31:0]  = cfg_wdata_i;
          3'd3: m_sta[47:32] = cfg_wdata_i[15:0];
          3'd4: m_mode       = cfg_wdata_i[5:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (run_cmp) begin
      chk(result_valid_o, exp_valid, "R3", "result_valid_o");
      chk(accept_o, exp_acc, cur_req, "accept_o");
      if (exp_valid) chk(hash_idx_o, exp_idx, "R2", "hash_idx_o");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    @(negedge clk_i); byte_valid_i = 0; sof_i = 0;
    repeat (n - 1) @(negedge clk_i);
  endtask

  task automatic put(input logic s, input logic [7:0] b);
    @(negedge clk_i); sof_i = s; byte_valid_i = 1; byte_i = b;
  endtask

  task automatic send(input logic [47:0] a, input int gap = 0);
    for (int i = 0; i < 6; i++) begin
      put(i == 0, a[i*8 +: 8]);
      if (gap > 0 && i < 5) begin
        @(negedge clk_i); byte_valid_i = 0; sof_i = 0;
        repeat (gap - 1) @(negedge clk_i);
      end
    end
  endtask

  task automatic cfg(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk_i); byte_valid_i = 0; sof_i = 0;
    cfg_we_i = 1; cfg_addr_i = ad; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic send_wr(input logic [47:0] a, input logic [2:0] ad, input logic [31:0] d);
    for (int i = 0; i < 6; i++) begin
      put(i == 0, a[i*8 +: 8]);
      if (i == 5) begin cfg_we_i = 1; cfg_addr_i = ad; cfg_wdata_i = d; end
    end
    @(negedge clk_i); cfg_we_i = 0; byte_valid_i = 0; sof_i = 0;
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] sta, a;
    sta = 48'h5E_4D_3C_2B_1A_02;

    repeat (3) @(negedge clk_i);
    chk(result_valid_o, 0, "R1", "valid in reset");
    chk(accept_o, 0, "R1", "accept in reset");
    chk(vlan_match_en_o, 0, "R1", "vlan in reset");
    rst_ni = 1;
    run_cmp = 1;

    // R1: cleared config rejects everything
    cur_req = "R1";
    send(PAUSE); send(BCAST); send(48'h0); idle(3);

    // R2: pause address index
    cur_req = "R2";
    send(PAUSE); idle(3);
    chk(hash_idx_o, 6'h39, "R2", "pause index");

    // R7: hash filtering
    cur_req = "R7";
    cfg(3'd4, 32'h10);
    cfg(3'd1, 32'h0200_0000);
    send(PAUSE); send(48'h00_00_00_C2_80_01); send(48'h11_22_33_44_55_03); idle(3);
    cfg(3'd0, 32'hFFFF_FFFF); cfg(3'd1, 32'h0);
    for (int i = 0; i < 20; i++) send(rnd48() | 48'h1);
    idle(3);

    // R6: all multicast
    cur_req = "R6";
    cfg(3'd4, 32'h02);
    for (int i = 0; i < 10; i++) send(rnd48() | 48'h1);
    for (int i = 0; i < 5; i++) send(rnd48() & ~48'h1);
    idle(3);

    // R8: broadcast only through its own bit
    cur_req = "R8";
    cfg(3'd0, 32'hFFFF_FFFF); cfg(3'd1, 32'hFFFF_FFFF);
    cfg(3'd4, 32'h12);
    send(BCAST); idle(3);
    chk(accept_o, 0, "R8", "bcast settled");
    cfg(3'd4, 32'h04);
    send(BCAST); send(PAUSE); idle(3);

    // R9: unicast station match
    cur_req = "R9";
    cfg(3'd2, sta[31:0]); cfg(3'd3, {16'h0, sta[47:32]});
    cfg(3'd4, 32'h01);
    send(sta); send(sta ^ 48'h0100_0000_0000); send(sta ^ 48'h0000_0000_0100);
    send(sta | 48'h1); idle(3);

    // R5: all frames
    cur_req = "R5";
    cfg(3'd4, 32'h08);
    send(BCAST); send(48'h0); send(PAUSE); send(rnd48()); idle(3);

    // R4: restart and pauses
    cur_req = "R4";
    cfg(3'd4, 32'h01);
    put(1, sta[7:0]); put(0, 8'hAA); put(0, 8'hBB);
    send(sta); idle(2);
    put(1, sta[7:0]); put(0, sta[15:8]);
    @(negedge clk_i); byte_valid_i = 0; sof_i = 1;
    for (int i = 2; i < 6; i++) put(0, sta[i*8 +: 8]);
    idle(3);
    send(sta, 2); idle(3);

    // R3: trailing bytes after the sixth ignored
    cur_req = "R3";
    send(sta);
    for (int i = 0; i < 8; i++) put(0, 8'h5A);
    idle(4);

    // R10: config write on the final byte; vlan bit
    cur_req = "R10";
    cfg(3'd4, 32'h00);
    send_wr(PAUSE, 3'd4, 32'h08); idle(2);
    send(PAUSE); idle(2);
    cfg(3'd4, 32'h10); cfg(3'd1, 32'h0); cfg(3'd0, 32'h0);
    send_wr(PAUSE, 3'd1, 32'h0200_0000); idle(2);
    send(PAUSE); idle(2);
    cfg(3'd4, 32'h20);
    chk(vlan_match_en_o, 1, "R10", "vlan enable");
    cfg(3'd4, 32'h00);
    chk(vlan_match_en_o, 0, "R10", "vlan disable");

    // R11: random combined modes, back-to-back frames
    cur_req = "R11";
    for (int f = 0; f < 300; f++) begin
      if (f % 20 == 0) begin
        cfg(3'd0, $urandom()); cfg(3'd1, $urandom());
        cfg(3'd4, $urandom() & 32'h37);
      end
      case ($urandom_range(0, 4))
        0: a = BCAST;
        1: a = sta;
        2: a = sta ^ (48'h1 << $urandom_range(1, 47));
        3: a = rnd48() | 48'h1;
        default: a = rnd48() & ~48'h1;
      endcase
      send(a, ($urandom_range(0, 3) == 0) ? 1 : 0);
    end
    idle(4);

    run_cmp = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule